// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a record of loads that were hoisted above stores whose addresses could not be proven disjoint from the load. Each record names the destination register and the memory region the load read. When the program later reaches the point where the original load belonged, it asks the table whether the record for that register is still present. A present record means no intervening write touched the region, so the speculative value is good. A missing record means the value must be fetched again or the dependent work redone.

Records are found in two ways. Allocations, checks and targeted removals compare register tags. Memory events compare address ranges against every record at once, so several records can be dropped in one cycle. A register tag is the register number together with a one-bit register-file selector. Memory regions are kept at cache-line granularity, so a plain store drops every record that shares a line with any byte it writes.

The check answer is combinational in the cycle of the request. All table updates take effect at the next clock edge.

Top module: `adv_ld_table`

## Requirements
- R1: After reset no record is valid, and every check reports a miss.
- R2: An allocate without the deferred flag inserts a record that a check sees from the next cycle. A check in the same cycle as that allocate does not see it.
- R3: An allocate first drops any record that has the same register tag, so at most one record per tag exists. A re-allocated tag is tracked only at its newest address.
- R4: The register tag is the register-file selector (0 integer, 1 floating point) together with the register number. The same number in the other file never matches.
- R5: An allocate with the deferred flag set drops any record with that tag and inserts nothing, so a later check of that tag misses.
- R6: A check reports hit when a valid record holds its tag. With the clear flag set, the record is removed after the hit is reported; without it, the record stays.
- R7: The invalidate-all input removes every record. Invalidate-by-tag removes only the record holding that tag.
- R8: Memory mode 0 (store) covers bytes addr through addr+len-1, with len 0 treated as 1, widened to whole 64-byte lines. It removes every record whose lines overlap those lines, several in one cycle if needed. A record's region is its address plus 1, 2, 4, 8 or 16 bytes for size codes 0 to 4; codes above 4 mean 16 bytes.
- R9: A store-mode request with the spill flag set changes nothing.
- R10: Memory mode 1 removes every record that touches the 64-byte line containing the address. Mode 2 removes every record that touches the 4096-byte page containing the address. Mode 3 changes nothing.
- R11: When a memory, invalidate-all or invalidate-by-tag request removes a record in the same cycle as a check of that record, the check reports a miss.
- R12: The table holds 32 records. New records go to the lowest free slot. When no slot is free, the victim slot is taken round-robin, starting at slot 0 after reset and advancing by one on each replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| al_valid | input | 1 | Allocate request |
| al_rtype | input | 1 | Allocate register file (0 int, 1 fp) |
| al_rnum | input | 7 | Allocate register number (first target for paired loads) |
| al_size | input | 3 | Allocate access size code |
| al_paddr | input | 40 | Allocate physical address |
| al_defer | input | 1 | Load produced a deferred exception |
| ck_valid | input | 1 | Check request |
| ck_rtype | input | 1 | Check register file |
| ck_rnum | input | 7 | Check register number |
| ck_clear | input | 1 | Remove the record after the check |
| ck_hit | output | 1 | Record present, speculation holds |
| mi_valid | input | 1 | Memory invalidation request |
| mi_mode | input | 2 | 0 store, 1 line eviction, 2 page purge, 3 none |
| mi_addr | input | 40 | Memory invalidation address |
| mi_len | input | 5 | Store byte length |
| mi_spill | input | 1 | Store is a register-stack spill |
| inv_all | input | 1 | Remove every record |
| it_valid | input | 1 | Remove the record with a given tag |
| it_rtype | input | 1 | Register file of the tag to remove |
| it_rnum | input | 7 | Register number of the tag to remove |

## Verification
Records are placed inside one line, at the end of a line, and straddling two lines. Stores then hit the neighbouring line, span two lines, or have zero length, which shows whether overlap is computed on line ranges at both ends. Page purges land on entries at both edges of a page and just past it, separating page from line granularity. Tag traffic pairs the same number in both register files, re-allocates a tag, mixes deferred and clearing requests, and overfills the table, which separates tag matching from address matching and shows the replacement order.

// File: rtl/adv_ld_pkg.sv
package adv_ld_pkg;

   typedef enum logic [1:0] {
      MI_STORE = 2'd0,
      MI_LINE  = 2'd1,
      MI_PAGE  = 2'd2,
      MI_NONE  = 2'd3
   } mi_mode_e;

   // highest byte offset of an access, from its size code
   function automatic logic [4:0] size_span(input logic [2:0] code);
      case (code)
         3'd0:    size_span = 5'd0;
         3'd1:    size_span = 5'd1;
         3'd2:    size_span = 5'd3;
         3'd3:    size_span = 5'd7;
         default: size_span = 5'd15;
      endcase
   endfunction

endpackage

// File: rtl/ldt_span_cmp.sv
module ldt_span_cmp #(
   parameter int W = 34
) (
   input  logic [W-1:0] a_lo,
   input  logic [W-1:0] a_hi,
   input  logic [W-1:0] b_lo,
   input  logic [W-1:0] b_hi,
   output logic         hit
);
   // two closed line ranges share at least one line
   assign hit = (a_lo <= b_hi) && (b_lo <= a_hi);
endmodule

// File: rtl/ldt_victim.sv
module ldt_victim #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     free,
   input  logic [IDX_W-1:0] rr,
   output logic [IDX_W-1:0] idx,
   output logic             any_free
);
   logic [IDX_W-1:0] first_free;

   always_comb begin
      first_free = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (free[k]) first_free = IDX_W'(k);
      end
   end

   assign any_free = |free;
   assign idx      = any_free ? first_free : rr;
endmodule

// File: rtl/adv_ld_table.sv
module adv_ld_table
   import adv_ld_pkg::*;
#(
   parameter int ENTRIES    = 32,
   parameter int RNUM_W     = 7,
   parameter int PA_W       = 40,
   parameter int LINE_BYTES = 64,
   parameter int PAGE_BYTES = 4096,
   parameter int LEN_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              al_valid,
   input  logic              al_rtype,
   input  logic [RNUM_W-1:0] al_rnum,
   input  logic [2:0]        al_size,
   input  logic [PA_W-1:0]   al_paddr,
   input  logic              al_defer,
   input  logic              ck_valid,
   input  logic              ck_rtype,
   input  logic [RNUM_W-1:0] ck_rnum,
   input  logic              ck_clear,
   output logic              ck_hit,
   input  logic              mi_valid,
   input  logic [1:0]        mi_mode,
   input  logic [PA_W-1:0]   mi_addr,
   input  logic [LEN_W-1:0]  mi_len,
   input  logic              mi_spill,
   input  logic              inv_all,
   input  logic              it_valid,
   input  logic              it_rtype,
   input  logic [RNUM_W-1:0] it_rnum
);
   localparam int TAG_W     = RNUM_W + 1;
   localparam int IDX_W     = $clog2(ENTRIES);
   localparam int LINE_SH   = $clog2(LINE_BYTES);
   localparam int PAGE_SH   = $clog2(PAGE_BYTES);
   localparam int LN_W      = PA_W - LINE_SH;
   localparam int PG_IN_LN  = PAGE_SH - LINE_SH;
   localparam logic [LN_W-1:0] PG_MASK = LN_W'((64'd1 << PG_IN_LN) - 64'd1);

   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert ((1 << LINE_SH) == LINE_BYTES) else $error("LINE_BYTES must be a power of two");
      assert ((1 << PAGE_SH) == PAGE_BYTES) else $error("PAGE_BYTES must be a power of two");
      assert (PAGE_BYTES > LINE_BYTES) else $error("page must be larger than a line");
      assert (PA_W > PAGE_SH) else $error("address narrower than a page");
   end

   // ---------------- storage ----------------
   logic [ENTRIES-1:0] vld;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [LN_W-1:0]    lo_q  [ENTRIES];
   logic [LN_W-1:0]    hi_q  [ENTRIES];
   logic [IDX_W-1:0]   rr_q;

   // ---------------- request decode ----------------
   logic [TAG_W-1:0] al_tag, ck_tag, it_tag;
   assign al_tag = {al_rtype, al_rnum};
   assign ck_tag = {ck_rtype, ck_rnum};
   assign it_tag = {it_rtype, it_rnum};

   logic [PA_W-1:0] al_end;
   logic [LN_W-1:0] al_lo, al_hi;
   assign al_end = al_paddr + PA_W'(size_span(al_size));
   assign al_lo  = LN_W'(al_paddr >> LINE_SH);
   assign al_hi  = LN_W'(al_end >> LINE_SH);

   logic [LEN_W-1:0] mi_span;
   logic [PA_W-1:0]  mi_end;
   logic [LN_W-1:0]  mi_line, mi_end_line;
   assign mi_span     = (mi_len == '0) ? '0 : mi_len - LEN_W'(1);
   assign mi_end      = mi_addr + PA_W'(mi_span);
   assign mi_line     = LN_W'(mi_addr >> LINE_SH);
   assign mi_end_line = LN_W'(mi_end >> LINE_SH);

   logic            inv_act;
   logic [LN_W-1:0] r_lo, r_hi;

   always_comb begin
      inv_act = 1'b0;
      r_lo    = mi_line;
      r_hi    = mi_line;
      case (mi_mode_e'(mi_mode))
         MI_STORE: begin
            inv_act = mi_valid && !mi_spill;
            r_hi    = mi_end_line;
         end
         MI_LINE: inv_act = mi_valid;
         MI_PAGE: begin
            inv_act = mi_valid;
            r_lo    = mi_line & ~PG_MASK;
            r_hi    = mi_line | PG_MASK;
         end
         default: inv_act = 1'b0;
      endcase
   end

   // ---------------- per-entry match network ----------------
   logic [ENTRIES-1:0] ovl, al_m, ck_m, it_m;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      ldt_span_cmp #(.W(LN_W)) u_cmp (
         .a_lo (lo_q[i]),
         .a_hi (hi_q[i]),
         .b_lo (r_lo),
         .b_hi (r_hi),
         .hit  (ovl[i])
      );
      assign al_m[i] = vld[i] && (tag_q[i] == al_tag);
      assign ck_m[i] = vld[i] && (tag_q[i] == ck_tag);
      assign it_m[i] = vld[i] && (tag_q[i] == it_tag);
   end

   logic [ENTRIES-1:0] kill_inv, kill, surv;
   assign kill_inv = ({ENTRIES{inv_act}} & ovl)
                   | {ENTRIES{inv_all}}
                   | ({ENTRIES{it_valid}} & it_m);
   assign kill     = kill_inv
                   | ({ENTRIES{ck_valid && ck_clear}} & ck_m)
                   | ({ENTRIES{al_valid}} & al_m);
   assign surv     = vld & ~kill;

   // invalidations in the same cycle win over the check
   assign ck_hit = ck_valid && |(ck_m & ~kill_inv);

   // ---------------- insertion ----------------
   logic [IDX_W-1:0] vic_idx;
   logic             vic_free;
   logic             ins;
   assign ins = al_valid && !al_defer;

   ldt_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_vic (
      .free     (~surv),
      .rr       (rr_q),
      .idx      (vic_idx),
      .any_free (vic_free)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= '0;
         rr_q <= '0;
      end else begin
         vld <= surv;
         if (ins) begin
            vld[vic_idx] <= 1'b1;
            if (!vic_free)
               rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (ins) begin
         tag_q[vic_idx] <= al_tag;
         lo_q[vic_idx]  <= al_lo;
         hi_q[vic_idx]  <= al_hi;
      end
   end

   // ---------------- assertions ----------------
   AST_FILL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      al_valid && !al_defer |=> vld != '0); // R2

   AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      ck_valid |-> $onehot0(ck_m)); // R3

   AST_DEFER_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      al_valid && al_defer |=> $countones(vld) <= $past($countones(vld))); // R5

   AST_CLEAR_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      ck_valid && ck_clear && !al_valid |=> $countones(vld) <= $past($countones(vld))); // R6

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all && !al_valid |=> vld == '0); // R7

   AST_SPILL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      mi_valid && mi_mode == 2'd0 && mi_spill && !inv_all && !it_valid
      && !(ck_valid && ck_clear) && !al_valid |=> $stable(vld)); // R9

endmodule

// File: tb/adv_ld_table_tb_top.sv
`timescale 1ns/1ps
module adv_ld_table_tb_top;
   localparam int N = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        al_valid, al_rtype, al_defer;
   logic [6:0]  al_rnum;
   logic [2:0]  al_size;
   logic [39:0] al_paddr;
   logic        ck_valid, ck_rtype, ck_clear, ck_hit;
   logic [6:0]  ck_rnum;
   logic        mi_valid, mi_spill;
   logic [1:0]  mi_mode;
   logic [39:0] mi_addr;
   logic [4:0]  mi_len;
   logic        inv_all, it_valid, it_rtype;
   logic [6:0]  it_rnum;

   adv_ld_table dut_i (
      .clk(clk), .rst_n(rst_n),
      .al_valid(al_valid), .al_rtype(al_rtype), .al_rnum(al_rnum),
      .al_size(al_size), .al_paddr(al_paddr), .al_defer(al_defer),
      .ck_valid(ck_valid), .ck_rtype(ck_rtype), .ck_rnum(ck_rnum),
      .ck_clear(ck_clear), .ck_hit(ck_hit),
      .mi_valid(mi_valid), .mi_mode(mi_mode), .mi_addr(mi_addr),
      .mi_len(mi_len), .mi_spill(mi_spill),
      .inv_all(inv_all), .it_valid(it_valid), .it_rtype(it_rtype), .it_rnum(it_rnum)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural reference: slot list with round-robin pointer
   bit     m_v   [N];
   int     m_tag [N];
   longint m_lo  [N];
   longint m_hi  [N];
   int     m_rr;

   task automatic idle();
      al_valid = 0; al_rtype = 0; al_rnum = 0; al_size = 0; al_paddr = 0; al_defer = 0;
      ck_valid = 0; ck_rtype = 0; ck_rnum = 0; ck_clear = 0;
      mi_valid = 0; mi_mode = 0; mi_addr = 0; mi_len = 0; mi_spill = 0;
      inv_all = 0; it_valid = 0; it_rtype = 0; it_rnum = 0;
   endtask

   function automatic bit inv_kills(int e);
      longint rl, rh, ln;
      bit act;
      ln = longint'(mi_addr) >> 6;
      rl = ln; rh = ln; act = 0;
      if (mi_valid) begin
         case (mi_mode)
            2'd0: begin
               act = !mi_spill;
               rh  = (longint'(mi_addr) + ((mi_len == 0) ? 0 : longint'(mi_len) - 1)) >> 6;
            end
            2'd1: act = 1;
            2'd2: begin
               act = 1;
               rl  = (longint'(mi_addr) >> 12) << 6;
               rh  = rl + 63;
            end
            default: act = 0;
         endcase
      end
      if (inv_all) return 1;
      if (it_valid && m_tag[e] == int'({it_rtype, it_rnum})) return 1;
      return act && (m_lo[e] <= rh) && (rl <= m_hi[e]);
   endfunction

   // drive-set inputs are live; compare at negedge, then advance the model
   task automatic tick(string req);
      bit exp_hit;
      bit kill [N];
      int slot;
      longint bytes;
      @(negedge clk);
      exp_hit = 0;
      for (int e = 0; e < N; e++) begin
         kill[e] = 0;
         if (m_v[e]) begin
            if (inv_kills(e)) kill[e] = 1;
            else if (ck_valid && m_tag[e] == int'({ck_rtype, ck_rnum})) exp_hit = 1;
            if (ck_valid && ck_clear && m_tag[e] == int'({ck_rtype, ck_rnum})) kill[e] = 1;
            if (al_valid && m_tag[e] == int'({al_rtype, al_rnum})) kill[e] = 1;
         end
      end
      total++;
      if (ck_hit !== exp_hit) begin
         bad++;
         $display("FAIL %s: ck_hit actual=%0b expected=%0b (tag %0d)",
                  req, ck_hit, exp_hit, int'({ck_rtype, ck_rnum}));
      end
      for (int e = 0; e < N; e++) if (kill[e]) m_v[e] = 0;
      if (al_valid && !al_defer) begin
         slot = -1;
         for (int e = N - 1; e >= 0; e--) if (!m_v[e]) slot = e;
         if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
         end
         bytes = (al_size >= 4) ? 16 : (64'd1 << al_size);
         m_v[slot]   = 1;
         m_tag[slot] = int'({al_rtype, al_rnum});
         m_lo[slot]  = longint'(al_paddr) >> 6;
         m_hi[slot]  = (longint'(al_paddr) + bytes - 1) >> 6;
      end
      @(posedge clk);
      #1;
      idle();
   endtask

   task automatic alloc(bit t, int r, int sz, longint a, bit dfr);
      al_valid = 1; al_rtype = t; al_rnum = 7'(r); al_size = 3'(sz);
      al_paddr = 40'(a); al_defer = dfr;
   endtask

   task automatic chk(bit t, int r, bit clr);
      ck_valid = 1; ck_rtype = t; ck_rnum = 7'(r); ck_clear = clr;
   endtask

   task automatic mem(int md, longint a, int len, bit sp);
      mi_valid = 1; mi_mode = 2'(md); mi_addr = 40'(a); mi_len = 5'(len); mi_spill = sp;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      idle();
      for (int e = 0; e < N; e++) begin m_v[e] = 0; m_tag[e] = 0; m_lo[e] = 0; m_hi[e] = 0; end
      m_rr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: empty after reset
      chk(0, 5, 0); tick("R1");
      chk(1, 0, 0); tick("R1");

      // R2: visible only from the next cycle
      alloc(0, 5, 3, 64'h1000, 0); chk(0, 5, 0); tick("R2");
      chk(0, 5, 0); tick("R2");

      // R4: register file selects a distinct tag
      chk(1, 5, 0); tick("R4");
      alloc(1, 5, 3, 64'h2000, 0); tick("R4");
      chk(1, 5, 0); tick("R4");
      chk(0, 5, 0); tick("R4");

      // R3: re-allocation moves the tag to the newest address
      alloc(0, 5, 3, 64'h3000, 0); tick("R3");
      mem(0, 64'h1000, 8, 0); chk(0, 5, 0); tick("R3");
      chk(0, 5, 0); tick("R3");
      mem(0, 64'h3004, 1, 0); tick("R8");
      chk(0, 5, 0); tick("R8");
      chk(1, 5, 0); tick("R4");

      // R5: deferred allocate removes and never inserts
      alloc(0, 9, 3, 64'h4000, 0); tick("R5");
      alloc(0, 9, 3, 64'h4000, 1); tick("R5");
      chk(0, 9, 0); tick("R5");
      alloc(0, 10, 2, 64'h4100, 1); tick("R5");
      chk(0, 10, 0); tick("R5");

      // R6: plain check keeps, clearing check removes after reporting
      alloc(0, 11, 2, 64'h4200, 0); tick("R6");
      chk(0, 11, 0); tick("R6");
      chk(0, 11, 0); tick("R6");
      chk(0, 11, 1); tick("R6");
      chk(0, 11, 0); tick("R6");

      // R7: flush and targeted removal
      alloc(0, 12, 1, 64'h4300, 0); tick("R7");
      alloc(0, 13, 1, 64'h4340, 0); tick("R7");
      inv_all = 1; tick("R7");
      chk(0, 12, 0); tick("R7");
      chk(0, 13, 0); tick("R7");
      alloc(0, 12, 1, 64'h4300, 0); tick("R7");
      alloc(0, 13, 1, 64'h4340, 0); tick("R7");
      it_valid = 1; it_rtype = 0; it_rnum = 12; tick("R7");
      chk(0, 12, 0); tick("R7");
      chk(0, 13, 0); tick("R7");

      // R8: line-widened store overlap, straddling regions, zero length
      alloc(0, 20, 3, 64'h5000, 0); tick("R8");
      alloc(0, 21, 3, 64'h5038, 0); tick("R8");
      alloc(0, 22, 4, 64'h503C, 0); tick("R8");
      alloc(0, 23, 3, 64'h5080, 0); tick("R8");
      mem(0, 64'h5040, 1, 0); tick("R8");
      chk(0, 22, 0); tick("R8");
      chk(0, 20, 0); tick("R8");
      chk(0, 23, 0); tick("R8");
      mem(0, 64'h507F, 2, 0); tick("R8");
      chk(0, 23, 0); tick("R8");
      chk(0, 21, 0); tick("R8");
      mem(0, 64'h5000, 0, 0); tick("R8");
      chk(0, 20, 0); tick("R8");
      chk(0, 21, 0); tick("R8");

      // R9: spill stores are ignored; R10: mode 3 is ignored
      alloc(0, 24, 3, 64'h6000, 0); tick("R9");
      mem(0, 64'h6000, 8, 1); tick("R9");
      chk(0, 24, 0); tick("R9");
      mem(3, 64'h6000, 8, 0); tick("R10");
      chk(0, 24, 0); tick("R10");

      // R10: line eviction and page purge
      mem(1, 64'h6010, 0, 0); tick("R10");
      chk(0, 24, 0); tick("R10");
      alloc(0, 25, 3, 64'h7008, 0); tick("R10");
      alloc(0, 26, 3, 64'h7FF8, 0); tick("R10");
      alloc(0, 27, 3, 64'h8000, 0); tick("R10");
      mem(2, 64'h7400, 1, 0); tick("R10");
      chk(0, 25, 0); tick("R10");
      chk(0, 26, 0); tick("R10");
      chk(0, 27, 0); tick("R10");

      // R11: same-cycle invalidation beats the check
      alloc(0, 28, 3, 64'h9000, 0); tick("R11");
      mem(0, 64'h9020, 4, 0); chk(0, 28, 0); tick("R11");
      chk(0, 28, 0); tick("R11");
      alloc(0, 29, 3, 64'h9100, 0); tick("R11");
      inv_all = 1; chk(0, 29, 0); tick("R11");

      // R12: fill all slots then replace round-robin
      for (int k = 0; k < N; k++) begin
         alloc(1, 40 + k, 3, 64'h10000 + 64'(k) * 64'h40, 0); tick("R12");
      end
      for (int k = 0; k < N; k++) begin
         chk(1, 40 + k, 0); tick("R12");
      end
      alloc(0, 100, 3, 64'h20000, 0); tick("R12");
      chk(1, 40, 0); tick("R12");
      chk(1, 41, 0); tick("R12");
      chk(0, 100, 0); tick("R12");
      alloc(0, 101, 3, 64'h20040, 0); tick("R12");
      chk(1, 41, 0); tick("R12");
      chk(1, 42, 0); tick("R12");
      chk(0, 101, 0); tick("R12");

      finish_run();
   end
endmodule